// File: doc/BRIEF.md
# Programmable Memory Delay Line

This block delays a stream of data words by a number of clock cycles that software or surrounding logic can change while running. Rather than a long chain of flip-flops, it keeps the in-flight words in a single-port memory and walks that memory with a wrapping address counter. On every enabled cycle the word stored at the current address is read out and the incoming word is written to that same address. The delay is set by how many addresses the counter visits before it returns to a given one.

The data path has no valid/ready handshake and no back-pressure. The clock enable `en` is the only flow control. When it is low, every state element holds, so the delay is counted in enabled cycles. The runtime limit `max_count` is registered once before the counter uses it. An optional register on the memory read path adds one cycle of latency and can be chosen by parameter. Reset is synchronous and its polarity is a parameter. Reset does not clear the memory, so an output that comes from a word written before reset is stale.

Top module: `ram_delay_line`

## Requirements
- R1: A word sampled on an enabled edge appears on `dout` right after the enabled edge that comes `max_count + 3` enabled edges later when `OUT_REG = 1`, or `max_count + 2` enabled edges later when `OUT_REG = 0`.
- R2: An edge with `en` low changes neither `dout` nor the address counter. The write for that cycle is skipped, so the delay counts enabled edges only.
- R3: On each enabled edge the address counter steps up by one until it reaches the registered limit, and then it returns to 0. It visits addresses 0 through `max_count`.
- R4: If the registered limit falls below the current address, the next enabled edge sends the counter to 0. The delay then settles at the new value.
- R5: Reset is synchronous and acts for `rst` high when `RST_ACTIVE_HIGH = 1`, or for `rst` low when it is 0. It clears the counter, the registered limit, the input word register, the memory read latch and the output register, so `dout` reads 0 afterwards.
- R6: Reset leaves the memory contents alone. Even so, from the first enabled edge after reset onward, every output produced at the latency of R1 carries a word written after that reset.
- R7: The width of `max_count` is ceil(log2(MAX_DELAY - 2)) bits when `OUT_REG = 1`, or ceil(log2(MAX_DELAY - 1)) bits when it is 0, and never less than 1 bit. Both the minimum value 0 and the largest value that fits produce the delay given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, with polarity set by `RST_ACTIVE_HIGH` |
| en | input | 1 | Clock enable; all state holds while it is low |
| max_count | input | CNT_W | Highest address the counter visits; it sets the delay |
| din | input | W | Data word entering the line |
| dout | output | W | Delayed data word |

## Verification
The assertions assume that `rst`, `en` and `max_count` are driven with known values from the first clock edge onward. They also assume reset is held long enough to clear the counter. They do not assume anything about the memory contents. The bench drives all inputs half a cycle away from the rising edge, and it applies reset for two edges before each sequence. It keeps `max_count` steady during a sequence, except in one test where it deliberately lowers the limit. In that test the outputs are checked only once the line has had time to refill.

// File: rtl/ram_dly_pkg.sv
package ram_dly_pkg;

  // Width of the runtime limit port; kept at least one bit wide.
  function automatic int limit_width(input int max_delay, input bit out_reg);
    int span;
    int w;
    span = max_delay - (out_reg ? 2 : 1);
    w = $clog2(span);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/dly_addr_seq.sv
module dly_addr_seq #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_act,
  input  logic             en,
  input  logic [CNT_W-1:0] limit_in,
  output logic [CNT_W-1:0] addr
);

  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst_act) begin
      lim_q <= '0;
      cnt   <= '0;
    end else if (en) begin
      lim_q <= limit_in;
      cnt   <= (cnt >= lim_q) ? '0 : cnt + 1'b1;
    end
  end

  assign addr = cnt;

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (rst_act)
    (en && cnt < lim_q) |=> (cnt == $past(cnt) + 1'b1));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst_act)
    (en && cnt >= lim_q) |=> (cnt == '0));

  // R2
  hold_ctr_chk: assert property (@(posedge clk) disable iff (rst_act)
    (!en) |=> $stable(cnt));

  // R5
  reset_clear_chk: assert property (@(posedge clk)
    rst_act |=> (cnt == '0 && lim_q == '0));

endmodule

// File: rtl/dly_sp_ram.sv
module dly_sp_ram #(
  parameter int W  = 1,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_act,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  // Memory array: written only when enabled, never reset.
  always_ff @(posedge clk) begin
    if (en) mem[addr] <= wdata;
  end

  // Read latch sees the contents before this cycle's write (read-first).
  always_ff @(posedge clk) begin
    if (rst_act)  rdata <= '0;
    else if (en)  rdata <= mem[addr];
  end

  // R2
  hold_rd_chk: assert property (@(posedge clk) disable iff (rst_act)
    (!en) |=> $stable(rdata));

endmodule

// File: rtl/dly_out_stage.sv
module dly_out_stage #(
  parameter int W       = 1,
  parameter bit USE_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_act,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (USE_REG) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst_act)  q_r <= '0;
        else if (en)  q_r <= d;
      end
      assign q = q_r;
    end else begin : g_pass
      assign q = d;
    end
  endgenerate

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (rst_act)
    (!en) |=> $stable(q));

  // R5
  out_clear_chk: assert property (@(posedge clk)
    rst_act |=> (q == '0));

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line
  import ram_dly_pkg::*;
#(
  parameter int MAX_DELAY       = 3,
  parameter int W               = 1,
  parameter bit OUT_REG         = 1'b1,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int CNT_W          = limit_width(MAX_DELAY, OUT_REG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] max_count,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout
);

  logic             rst_act;
  logic [W-1:0]     din_q;
  logic [CNT_W-1:0] addr;
  logic [W-1:0]     rd_word;

  assign rst_act = RST_ACTIVE_HIGH ? rst : ~rst;

  // Input capture stage, aligned with the registered limit.
  always_ff @(posedge clk) begin
    if (rst_act)  din_q <= '0;
    else if (en)  din_q <= din;
  end

  dly_addr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk      (clk),
    .rst_act  (rst_act),
    .en       (en),
    .limit_in (max_count),
    .addr     (addr)
  );

  dly_sp_ram #(.W(W), .AW(CNT_W)) u_ram (
    .clk     (clk),
    .rst_act (rst_act),
    .en      (en),
    .addr    (addr),
    .wdata   (din_q),
    .rdata   (rd_word)
  );

  dly_out_stage #(.W(W), .USE_REG(OUT_REG)) u_out (
    .clk     (clk),
    .rst_act (rst_act),
    .en      (en),
    .d       (rd_word),
    .q       (dout)
  );

  // R5
  in_clear_chk: assert property (@(posedge clk)
    rst_act |=> (din_q == '0));

endmodule

// File: tb/tb_ram_delay_line.sv
module tb_ram_delay_line;

  localparam int W    = 8;
  localparam int MAXD = 34;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [5:0] maxc = '0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout_r, dout_n, dout_l;

  always #4 clk = ~clk;  // 125 MHz

  ram_delay_line #(.MAX_DELAY(MAXD), .W(W), .OUT_REG(1'b1), .RST_ACTIVE_HIGH(1'b1)) dut (
    .clk(clk), .rst(rst), .en(en), .max_count(maxc[4:0]), .din(din), .dout(dout_r));

  ram_delay_line #(.MAX_DELAY(MAXD), .W(W), .OUT_REG(1'b0), .RST_ACTIVE_HIGH(1'b1)) dut_nr (
    .clk(clk), .rst(rst), .en(en), .max_count(maxc), .din(din), .dout(dout_n));

  ram_delay_line #(.MAX_DELAY(MAXD), .W(W), .OUT_REG(1'b1), .RST_ACTIVE_HIGH(1'b0)) dut_al (
    .clk(clk), .rst(~rst), .en(en), .max_count(maxc[4:0]), .din(din), .dout(dout_l));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] hist [4096];
  int e;
  int base;

  // {max_count, cycles, enable percent}
  localparam int unsigned VEC [7] = '{
    (0  << 24) | (120 << 8) | 100,
    (0  << 24) | (150 << 8) | 60,
    (1  << 24) | (150 << 8) | 75,
    (5  << 24) | (200 << 8) | 50,
    (17 << 24) | (300 << 8) | 90,
    (31 << 24) | (300 << 8) | 100,
    (31 << 24) | (400 << 8) | 40
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    en  = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    chk("R5 reset clears output (reg)", dout_r, '0);
    chk("R5 reset clears output (no reg)", dout_n, '0);
    chk("R5 active-low reset clears output", dout_l, '0);
    @(negedge clk);
    rst = 1'b0;
    e = 0;
    base = 0;
  endtask

  task automatic run(input int mc, input int ncyc, input int pct, input int skip);
    logic [W-1:0] pr, pn, pl;
    base = e + skip;
    maxc = mc[5:0];
    pr = dout_r; pn = dout_n; pl = dout_l;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      en  = ($urandom_range(99) < pct);
      din = W'($urandom);
      @(posedge clk);
      #2;
      if (en) begin
        int idx;
        idx = e;
        hist[idx] = din;
        e++;
        if (idx - (mc + 3) >= base)
          chk("R1 R6 R7 latency with output reg", dout_r, hist[idx - (mc + 3)]);
        if (idx - (mc + 2) >= base)
          chk("R1 R6 R7 latency without output reg", dout_n, hist[idx - (mc + 2)]);
        chk("R5 active-low reset variant matches", dout_l, dout_r);
      end else begin
        chk("R2 hold on disabled edge (reg)", dout_r, pr);
        chk("R2 hold on disabled edge (no reg)", dout_n, pn);
        chk("R2 hold on disabled edge (active-low)", dout_l, pl);
      end
      pr = dout_r; pn = dout_n; pl = dout_l;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    e = 0;
    base = 0;
    // Table-driven sequences, each from reset (R1, R2, R3, R5, R6, R7)
    for (int v = 0; v < 7; v++) begin
      do_reset();
      run(int'(VEC[v] >> 24), int'((VEC[v] >> 8) & 16'hFFFF), int'(VEC[v] & 8'hFF), 0);
    end

    // R4: lower the limit while the counter is above it, no reset
    do_reset();
    run(20, 150, 90, 0);
    run(2, 200, 80, 40);

    // R3: raise the limit again mid-stream, then settle
    run(12, 200, 100, 40);

    // R5: reset mid-stream, then first outputs after reset are clean
    do_reset();
    run(3, 100, 100, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule